// File: doc/BRIEF.md
# Cell Header Subport Field Inserter

This block sits in a byte-wide receive cell path. Each cell is framed by a start-of-cell flag on its first byte. The block writes the number of the PHY port the cell arrived on into a subport field inside the cell header. It then forwards the stream one cycle later. The field placement is programmable. A starting byte and a starting bit give the position of the field's most significant bit. A width sets how many port bits are written. A tag-mode flag lengthens the header region in which writing is allowed.

The field is written MSB first. It moves downward through the bits of a byte, and when it runs past bit 0 it continues at bit 7 of the next byte. Field bits that would land beyond the header region are dropped, so payload bytes always leave the block unchanged. The configuration and the port number are taken at the start-of-cell byte and held for the rest of that cell. Cell buffering, header checksum recomputation and the choice of the active port belong to neighbouring logic.

Top module: `subport_inserter`

## Requirements
- R1: Every input byte with `in_valid` high appears on `out_data` with `out_valid` high exactly one clock later. `out_soc` is high on that output cycle if and only if `in_soc` was high with the byte. No output is valid in a cycle that follows an idle input cycle.
- R2: While `rst_n` is low, `out_valid`, `out_soc` and `out_data` are all zero at the next clock, whatever the inputs are.
- R3: Byte index 0 is the start-of-cell byte. A header bit is numbered by its offset, byte index times 8 plus (7 minus its bit number). With start byte `cfg_pos[2:0]` and start bit `cfg_pos[5:3]`, the field MSB goes at offset start byte times 8 plus (7 minus start bit). Field bit k, counted from the MSB, goes at that offset plus k. When the start bit is 7 the MSB lands in bit 7 of the start byte, and when it is 0 the MSB lands in bit 0.
- R4: A field that uses bit 0 of a byte continues at bit 7 of the next byte, with its next lower port bit.
- R5: `cfg_width` gives the number of port bits written, from 1 to 5. The port's least significant `width` bits are written MSB first. The codes 0, 6 and 7 act as 5.
- R6: The header region is byte indices 0 to 3 when `cfg_tag_on` is 0, and byte indices 0 to 7 when it is 1. Field bits whose offset falls outside that region are dropped. A field that starts beyond the region changes nothing.
- R7: Payload bytes (index past the header region), header bytes outside the field, and bits outside the field inside a partly covered byte all leave the block equal to their input values.
- R8: Configuration and `in_port` are sampled with the start-of-cell byte. Changes made to them later in the same cell do not affect that cell.
- R9: Bytes that arrive after reset and before the first start-of-cell pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte qualifier |
| in_soc | input | 1 | Marks the first byte of a cell |
| in_data | input | 8 | Input cell byte |
| in_port | input | 5 | Originating PHY port number, used at start-of-cell |
| cfg_tag_on | input | 1 | 1 extends the header region to eight bytes |
| cfg_pos | input | 6 | [2:0] start byte, [5:3] start bit of the field MSB |
| cfg_width | input | 3 | Field width code |
| out_valid | output | 1 | Output byte qualifier |
| out_soc | output | 1 | Start-of-cell delayed alongside the data |
| out_data | output | 8 | Output byte with the field inserted |

## Verification
The start-of-cell byte is modified using the live configuration inputs. In that same cycle the capture register loads the settings for the rest of the cell, and the previous cell's final byte may still be in the output register. The bench provokes this clash in two ways. It sends cells back to back with no gap, each with different settings. It also changes the configuration and port inputs on the byte right after a start-of-cell. The scoreboard computes every byte from the settings that were present at that cell's start and compares the output one cycle after the input, so a setting that leaks across the boundary shows up as a data mismatch.

// File: rtl/subport_ins_pkg.sv
// Package: shared sizes and the configuration record for the subport
// inserter. Assumes a byte-wide stream and a header of at most eight bytes.
package subport_ins_pkg;
    parameter int unsigned SPI_PORT_W   = 5;
    parameter int unsigned SPI_WID_W    = $clog2(SPI_PORT_W + 1);
    parameter int unsigned SPI_BASE_HDR = 4;
    parameter int unsigned SPI_TAG_HDR  = 8;
    parameter int unsigned SPI_IDX_W    = $clog2(SPI_TAG_HDR) + 1;
    parameter int unsigned SPI_POS_W    = SPI_IDX_W + 3;

    typedef struct packed {
        logic                 tag_on;
        logic [2:0]           start_byte;
        logic [2:0]           bit_loc;
        logic [SPI_WID_W-1:0] width;
    } ins_cfg_t;

    // Map out-of-range width codes onto the full port width.
    function automatic logic [SPI_WID_W-1:0] norm_width(input logic [SPI_WID_W-1:0] w);
        if (w == '0 || w > SPI_WID_W'(SPI_PORT_W))
            return SPI_WID_W'(SPI_PORT_W);
        return w;
    endfunction
endpackage

// File: rtl/subport_cell_tracker.sv
// Cell tracker: counts byte positions within a cell and holds the settings
// taken at start-of-cell. The start-of-cell byte itself sees the live inputs.
// Assumes in_soc is only meaningful together with in_valid.
module subport_cell_tracker
    import subport_ins_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_soc,
    input  ins_cfg_t              live_cfg,
    input  logic [SPI_PORT_W-1:0] live_port,
    output logic [SPI_IDX_W-1:0]  byte_idx,
    output ins_cfg_t              eff_cfg,
    output logic [SPI_PORT_W-1:0] eff_port
);
    localparam logic [SPI_IDX_W-1:0] IDX_MAX = '1;

    logic [SPI_IDX_W-1:0]  cnt_q;
    ins_cfg_t              cfg_q;
    logic [SPI_PORT_W-1:0] port_q;

    // Count bytes after start-of-cell (saturating) and capture settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= IDX_MAX;
            cfg_q  <= '0;
            port_q <= '0;
        end else if (in_valid) begin
            if (in_soc) begin
                cnt_q  <= SPI_IDX_W'(1);
                cfg_q  <= live_cfg;
                port_q <= live_port;
            end else if (cnt_q != IDX_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Select live settings on the start byte, held settings afterwards.
    always_comb begin
        byte_idx = in_soc ? '0 : cnt_q;
        eff_cfg  = in_soc ? live_cfg : cfg_q;
        eff_port = in_soc ? live_port : port_q;
    end
endmodule

// File: rtl/subport_bit_mapper.sv
// Bit mapper: purely combinational. For each bit of the current byte it
// decides whether that bit belongs to the subport field and, if so, which
// port bit it carries. Assumes byte_idx saturates past the header region.
module subport_bit_mapper
    import subport_ins_pkg::*;
(
    input  logic [SPI_IDX_W-1:0]  byte_idx,
    input  ins_cfg_t              cfg,
    input  logic [SPI_PORT_W-1:0] port,
    input  logic [7:0]            din,
    output logic [7:0]            dout
);
    logic [SPI_WID_W-1:0]  w_eff;
    logic [SPI_PORT_W-1:0] fld_al;
    logic [SPI_POS_W-1:0]  first_pos;
    logic [SPI_IDX_W-1:0]  hdr_len;
    logic                  in_hdr;

    // Left-align the field and locate its MSB offset within the header.
    always_comb begin
        w_eff     = norm_width(cfg.width);
        fld_al    = port << (SPI_PORT_W - 32'(w_eff));
        first_pos = SPI_POS_W'({cfg.start_byte, 3'b000}) + SPI_POS_W'(3'd7 - cfg.bit_loc);
        hdr_len   = cfg.tag_on ? SPI_IDX_W'(SPI_TAG_HDR) : SPI_IDX_W'(SPI_BASE_HDR);
        in_hdr    = byte_idx < hdr_len;
    end

    for (genvar j = 0; j < 8; j++) begin : g_bit
        logic [SPI_POS_W-1:0]  abs_pos;
        logic [SPI_POS_W-1:0]  rel;
        logic [SPI_PORT_W-1:0] sh;
        logic                  hit;
        // Per-bit offset test and selection of the matching port bit.
        assign abs_pos = {byte_idx, 3'(7 - j)};
        assign rel     = abs_pos - first_pos;
        assign sh      = fld_al << rel;
        assign hit     = in_hdr && (abs_pos >= first_pos) && (rel < SPI_POS_W'(w_eff));
        assign dout[j] = hit ? sh[SPI_PORT_W-1] : din[j];
    end
endmodule

// File: rtl/subport_out_stage.sv
// Output stage: the single pipeline register for data and framing.
// Assumes start-of-cell is qualified by valid before it is forwarded.
module subport_out_stage (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_soc,
    input  logic [7:0] din,
    output logic       out_valid,
    output logic       out_soc,
    output logic [7:0] out_data
);
    // Register the modified byte and its qualifiers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_soc   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_soc   <= in_valid && in_soc;
            out_data  <= din;
        end
    end
endmodule

// File: rtl/subport_inserter.sv
// Top: inserts the originating port number into a programmable header
// field of each received cell, with one cycle of latency. Assumes the
// neighbour supplies the port number and settings with the start byte.
module subport_inserter
    import subport_ins_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_soc,
    input  logic [7:0]            in_data,
    input  logic [SPI_PORT_W-1:0] in_port,
    input  logic                  cfg_tag_on,
    input  logic [5:0]            cfg_pos,
    input  logic [SPI_WID_W-1:0]  cfg_width,
    output logic                  out_valid,
    output logic                  out_soc,
    output logic [7:0]            out_data
);
    ins_cfg_t              live_cfg;
    ins_cfg_t              eff_cfg;
    logic [SPI_IDX_W-1:0]  byte_idx;
    logic [SPI_PORT_W-1:0] eff_port;
    logic [7:0]            mapped;

    // Gather the configuration pins into one record.
    always_comb begin
        live_cfg.tag_on     = cfg_tag_on;
        live_cfg.start_byte = cfg_pos[2:0];
        live_cfg.bit_loc    = cfg_pos[5:3];
        live_cfg.width      = cfg_width;
    end

    subport_cell_tracker u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_soc    (in_soc),
        .live_cfg  (live_cfg),
        .live_port (in_port),
        .byte_idx  (byte_idx),
        .eff_cfg   (eff_cfg),
        .eff_port  (eff_port)
    );

    subport_bit_mapper u_map (
        .byte_idx (byte_idx),
        .cfg      (eff_cfg),
        .port     (eff_port),
        .din      (in_data),
        .dout     (mapped)
    );

    subport_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_soc    (in_soc),
        .din       (mapped),
        .out_valid (out_valid),
        .out_soc   (out_soc),
        .out_data  (out_data)
    );
endmodule

// File: rtl/subport_inserter_chk.sv
// Checker: timing and pass-through properties of the subport inserter,
// attached by bind. Keeps its own byte position count within each cell.
module subport_inserter_chk
    import subport_ins_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_soc,
    input logic [7:0]            in_data,
    input logic [5:0]            cfg_pos,
    input logic                  out_valid,
    input logic                  out_soc,
    input logic [7:0]            out_data
);
    logic [SPI_IDX_W-1:0] ck_idx;

    // Independent byte position within the current cell.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ck_idx <= '1;
        else if (in_valid)
            ck_idx <= in_soc ? SPI_IDX_W'(1) : ((ck_idx == '1) ? ck_idx : ck_idx + 1'b1);
    end

    p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_soc_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_soc) |=> out_soc);
    p_reset_clear_r2: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_soc && out_data == 8'h00));
    p_lead_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_soc && cfg_pos[2:0] != 3'd0) |=> (out_data == $past(in_data)));
    p_payload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_soc && ck_idx >= SPI_IDX_W'(SPI_TAG_HDR)) |=> (out_data == $past(in_data)));
endmodule

bind subport_inserter subport_inserter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_soc    (in_soc),
    .in_data   (in_data),
    .cfg_pos   (cfg_pos),
    .out_valid (out_valid),
    .out_soc   (out_soc),
    .out_data  (out_data)
);

// File: tb/sim_subport_inserter.sv
// Scoreboard bench: the driver pushes expected output bytes, the monitor
// pops and compares them one cycle after they were driven.
module sim_subport_inserter;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_soc = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [4:0] in_port = 5'h00;
    logic       cfg_tag_on = 1'b0;
    logic [5:0] cfg_pos = 6'h00;
    logic [2:0] cfg_width = 3'd5;
    logic       out_valid;
    logic       out_soc;
    logic [7:0] out_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;
    logic [31:0] lcg = 32'h1234_5678;

    logic [8:0] exp_q[$];
    int         stamp_q[$];
    string      tag_q[$];

    subport_inserter u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_soc(in_soc),
        .in_data(in_data), .in_port(in_port), .cfg_tag_on(cfg_tag_on),
        .cfg_pos(cfg_pos), .cfg_width(cfg_width), .out_valid(out_valid),
        .out_soc(out_soc), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] next_byte();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg[23:16];
    endfunction

    // Expected byte computed from the requirement's offset rule.
    function automatic logic [7:0] exp_byte(int idx, logic [7:0] d, logic [4:0] port,
                                            int sb, int bl, int w, bit tag);
        logic [7:0] r;
        int hdr;
        int we;
        int first;
        r = d;
        hdr = tag ? 8 : 4;
        we = (w == 0 || w > 5) ? 5 : w;
        first = sb * 8 + 7 - bl;
        if (idx >= hdr) return d;
        for (int k = 0; k < we; k++) begin
            int a;
            a = first + k;
            if (a / 8 == idx) r[7 - (a % 8)] = port[we - 1 - k];
        end
        return r;
    endfunction

    task automatic push_exp(logic soc, logic [7:0] d, string req);
        exp_q.push_back({soc, d});
        stamp_q.push_back(cyc);
        tag_q.push_back(req);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_soc = 1'b0;
        end
    endtask

    // Bytes with no start-of-cell: expected to pass unchanged (R9).
    task automatic send_raw(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_soc = 1'b0;
            in_data = next_byte();
            push_exp(1'b0, in_data, "R9");
        end
    endtask

    // One cell; disturb changes settings after the start byte (R8);
    // gap_at inserts an idle cycle after that byte index.
    task automatic send_cell(logic [4:0] port, bit tag, int sb, int bl, int w,
                             int n, int gap_at, bit disturb, string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_soc = (i == 0);
            in_data = next_byte();
            if (i == 0) begin
                in_port = port;
                cfg_tag_on = tag;
                cfg_pos = {3'(bl), 3'(sb)};
                cfg_width = 3'(w);
            end else if (i == 1 && disturb) begin
                in_port = ~port;
                cfg_tag_on = ~tag;
                cfg_pos = ~{3'(bl), 3'(sb)};
                cfg_width = 3'(w) ^ 3'd3;
            end
            push_exp(i == 0, exp_byte(i, in_data, port, sb, bl, w, tag), req);
            if (i == gap_at) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_soc = 1'b0;
            end
        end
    endtask

    // Monitor: compare each valid output with the queued expectation (R1).
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected output", {23'd0, out_soc, out_data}, 32'h0);
            end else begin
                logic [8:0] e;
                int st;
                string rq;
                e = exp_q.pop_front();
                st = stamp_q.pop_front();
                rq = tag_q.pop_front();
                check(out_data == e[7:0], rq, out_data, e[7:0]);
                check(out_soc == e[8], "R1 soc", out_soc, e[8]);
                check(cyc == st + 1, "R1 latency", cyc - st, 1);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        in_valid = 1'b1;
        in_soc = 1'b1;
        repeat (3) @(negedge clk);
        // R2: outputs held at zero during reset despite active inputs
        check(out_valid == 1'b0 && out_soc == 1'b0 && out_data == 8'h00, "R2 reset",
              {22'd0, out_valid, out_soc, out_data}, 32'h0);
        in_valid = 1'b0;
        in_soc = 1'b0;
        rst_n = 1'b1;
        idle(1);
        send_raw(3);                                      // R9
        idle(2);
        send_cell(5'h13, 0, 0, 0, 5, 10, -1, 0, "R4 wrap");   // R3 R4
        idle(1);
        send_cell(5'h0B, 0, 1, 7, 5, 10, -1, 0, "R3 place");  // R3
        idle(1);
        send_cell(5'h1F, 0, 2, 3, 1, 10, -1, 0, "R5 width1"); // R5
        send_cell(5'h15, 0, 0, 5, 0, 10, -1, 0, "R5 code0");  // R5 back to back
        send_cell(5'h0E, 0, 1, 2, 7, 10, -1, 0, "R5 code7");  // R5
        idle(1);
        send_cell(5'h1D, 0, 3, 1, 5, 10, -1, 0, "R6 drop");   // R6 R7
        send_cell(5'h1D, 1, 3, 1, 5, 12, -1, 0, "R6 tag");    // R6
        send_cell(5'h17, 1, 7, 0, 5, 12, -1, 0, "R6 tagend"); // R6 R7
        send_cell(5'h1F, 0, 5, 4, 5, 10, -1, 0, "R6 outside");// R6
        idle(1);
        send_cell(5'h09, 0, 1, 4, 4, 10, 2, 1, "R8 hold");    // R8 with gap
        send_cell(5'h12, 1, 4, 6, 3, 12, 5, 1, "R8 tag hold");// R8
        send_cell(5'h05, 0, 0, 7, 2, 10, -1, 0, "R7 partial");// R7
        idle(4);
        check(exp_q.size() == 0, "R1 drained", exp_q.size(), 0);
        // R2: reset asserted mid-stream clears outputs
        @(negedge clk);
        in_valid = 1'b1;
        in_soc = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_soc == 1'b0 && out_data == 8'h00, "R2 mid reset",
              {22'd0, out_valid, out_soc, out_data}, 32'h0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule